// File: doc/BRIEF.md
# Paged Host Register Interface

This block is the register front end of a multi-channel position tracking converter. A host reaches it through a 64-address I/O window placed by a set of base-address switches. A page register at the top of the window switches the rest of the window between three banks: live data (position, velocity, health, test control and a storage command), setup (excitation frequency, active-channel mask, signal amplitudes) and drive (a snapshot trigger, excitation amplitudes and an identification word).

Every 16-bit register is split into a low byte at an even offset and a high byte at the following odd offset, so narrow hosts can reach it. A full-word read at the even offset also stores its high byte, and the odd read then returns that stored byte, so the two halves always come from the same sample. Converter position and velocity pass through per-channel holding registers. A snapshot write freezes every channel together, and reading a channel's position releases that channel alone. Saving and factory restore start from magic words written to a command register. The request is held towards an external storage writer until it reports completion, and the register then returns to zero.

Top module: `paged_host_regs`

## Requirements
- R1: An access counts only when address bits [9:6] equal `base_sw`. A read outside the window returns 0000h on the next cycle, and a write outside it changes nothing.
- R2: Offset 1Fh on every page is the page select (0 live, 1 setup, 2 drive). A read of 1Fh returns the page in bits [1:0]. A write of the value 3 is ignored.
- R3: A read returns data on `bus_rdata` in the cycle after the strobe, and `bus_rdata` holds until the next read. An even-offset read of a mapped word returns the full word and stores its bits [15:8]. An odd-offset read returns that stored byte in bits [7:0].
- R4: A write at an even offset loads the full 16-bit word. A write at an odd offset loads `bus_wdata[7:0]` into bits [15:8] of the word. On the setup page, 00h is the frequency, 02h is the active mask (low byte only), and 04h+2i is the signal amplitude of channel i. On the drive page, 04h+2i is the excitation amplitude of channel i. All amplitudes are unsigned with 0.01 V per LSB.
- R5: On the live page, 00h+2i reads position and 08h+2i reads velocity of channel i. While a channel is unlatched these follow the inputs with one register delay. A write to drive-page offset 00h latches every channel at the same edge.
- R6: An even read of a channel's position on the live page unlatches that channel only. Its velocity then also tracks again, and other channels stay frozen.
- R7: Writing 5555h to live-page offset 1Ah raises `store_req` with `store_restore` low. The register reads back 5555h until `store_done`, and then reads 0000h.
- R8: Writing AAAAh raises `store_req` and `store_restore`. On `store_done`, the frequency, mask, signal and excitation registers return to their reset values and the command reads 0000h.
- R9: While a command is pending, further command writes are ignored. A command write of any value other than 5555h or AAAAh is ignored.
- R10: After reset the frequency is 400, all amplitudes are 0, the mask is all ones, the page is 0, no channel is latched, no command is pending, and test control equals `post_en` in bit 3 with the other bits clear.
- R11: Live-page offset 14h is test control. Only bits 0, 2 and 3 are writable. A pulse on `init_done` clears bit 3.
- R12: Reads of unmapped offsets, and of the write-only snapshot register, return 0000h, and writes to unmapped offsets change no output. Drive-page 18h reads the identification word (4C44h by default).
- R13: Live-page 10h reads health: bits [3:0] `sig_ok`, [7:4] `exc_ok`, [11:8] `test_ok` (for four channels).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sw | input | ADDR_W-6 | Switch-set window base |
| bus_addr | input | ADDR_W | Host address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pos_in | input | NUM_CH*16 | Converter positions, channel 0 in the low bits |
| vel_in | input | NUM_CH*16 | Converter velocities |
| sig_ok | input | NUM_CH | Signal present per channel |
| exc_ok | input | NUM_CH | Excitation present per channel |
| test_ok | input | NUM_CH | Test accuracy pass per channel |
| post_en | input | 1 | Power-on test enable, sampled in reset |
| init_done | input | 1 | Initiated test has finished |
| store_req | output | 1 | Storage operation pending |
| store_restore | output | 1 | Pending operation is a factory restore |
| store_done | input | 1 | Storage writer finished |
| exc_freq | output | 16 | Excitation frequency setting |
| active_mask | output | NUM_CH | Channels in use |
| test_ctrl | output | 4 | Test control bits |
| sig_amp | output | NUM_CH*16 | Signal amplitude per channel |
| exc_amp | output | NUM_CH*16 | Excitation amplitude per channel |

## Verification
Reads are tried as full words, as odd reads straight after their even partner, and as odd reads after an even read of a different word. This separates byte capture from a live high byte. The snapshot is tested by changing every input after the trigger and then reading channels out of order, mixing position and velocity reads. This tells a per-channel release apart from a global one and from none at all. Writes are sent to foreign windows, to unmapped and read-only offsets, to odd lanes and to an illegal page value. The command register gets a valid word, an invalid word, and a second command while busy, so that each kind of ignored write shows up against the model.

// File: rtl/pgh_pkg.sv
package pgh_pkg;
   localparam int WORD_W = 16;

   localparam logic [1:0] PG_LIVE  = 2'd0;
   localparam logic [1:0] PG_SETUP = 2'd1;
   localparam logic [1:0] PG_DRIVE = 2'd2;
   localparam logic [1:0] PG_BAD   = 2'd3;

   // live page
   localparam logic [5:0] OFS_POS   = 6'h00;
   localparam logic [5:0] OFS_VEL   = 6'h08;
   localparam logic [5:0] OFS_STAT  = 6'h10;
   localparam logic [5:0] OFS_TCTRL = 6'h14;
   localparam logic [5:0] OFS_CMD   = 6'h1A;
   // every page
   localparam logic [5:0] OFS_PAGE  = 6'h1F;
   // setup page
   localparam logic [5:0] OFS_FREQ  = 6'h00;
   localparam logic [5:0] OFS_MASK  = 6'h02;
   localparam logic [5:0] OFS_SIG   = 6'h04;
   // drive page
   localparam logic [5:0] OFS_SNAP  = 6'h00;
   localparam logic [5:0] OFS_EXC   = 6'h04;
   localparam logic [5:0] OFS_ID    = 6'h18;

   localparam logic [15:0] CMD_SAVE    = 16'h5555;
   localparam logic [15:0] CMD_RESTORE = 16'hAAAA;
   localparam logic [15:0] FREQ_RESET  = 16'd400;
   localparam logic [3:0]  TCTRL_WMASK = 4'b1101;
   localparam int          TC_INIT_BIT = 3;
endpackage

// File: rtl/pgh_window.sv
module pgh_window #(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-7:0] base_sw,
   output logic              hit,
   output logic [5:0]        ofs,
   output logic [5:0]        wofs,
   output logic              odd
);
   assign hit  = (addr[ADDR_W-1:6] == base_sw);
   assign ofs  = addr[5:0];
   assign wofs = {addr[5:1], 1'b0};
   assign odd  = addr[0];
endmodule

// File: rtl/pgh_hold.sv
module pgh_hold #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pos_in,
   input  logic [W-1:0] vel_in,
   input  logic         latch_all,
   input  logic         rel_i,
   output logic [W-1:0] pos_q,
   output logic [W-1:0] vel_q,
   output logic         lat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         vel_q <= '0;
         lat_q <= 1'b0;
      end else begin
         if (!lat_q) begin
            pos_q <= pos_in;
            vel_q <= vel_in;
         end
         if (latch_all)  lat_q <= 1'b1;
         else if (rel_i) lat_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pgh_cmd.sv
module pgh_cmd
   import pgh_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              store_done,
   output logic [WORD_W-1:0] cmd_q,
   output logic              store_req,
   output logic              store_restore,
   output logic              restore_fin
);
   logic busy;
   assign busy = (cmd_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (busy) begin
         if (store_done) cmd_q <= '0;
      end else if (cmd_wr && (wdata == CMD_SAVE || wdata == CMD_RESTORE)) begin
         cmd_q <= wdata;
      end
   end

   assign store_req     = busy;
   assign store_restore = (cmd_q == CMD_RESTORE);
   assign restore_fin   = store_restore && store_done;
endmodule

// File: rtl/paged_host_regs.sv
module paged_host_regs
   import pgh_pkg::*;
#(
   parameter int          NUM_CH    = 4,
   parameter int          ADDR_W    = 10,
   parameter logic [15:0] ID_WORD   = 16'h4C44,
   parameter logic [15:0] SIG_RESET = 16'h0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-7:0]        base_sw,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [15:0]              bus_wdata,
   output logic [15:0]              bus_rdata,
   input  logic [NUM_CH*16-1:0]     pos_in,
   input  logic [NUM_CH*16-1:0]     vel_in,
   input  logic [NUM_CH-1:0]        sig_ok,
   input  logic [NUM_CH-1:0]        exc_ok,
   input  logic [NUM_CH-1:0]        test_ok,
   input  logic                     post_en,
   input  logic                     init_done,
   output logic                     store_req,
   output logic                     store_restore,
   input  logic                     store_done,
   output logic [15:0]              exc_freq,
   output logic [NUM_CH-1:0]        active_mask,
   output logic [3:0]               test_ctrl,
   output logic [NUM_CH*16-1:0]     sig_amp,
   output logic [NUM_CH*16-1:0]     exc_amp
);
   localparam int                STAT_W     = 3 * NUM_CH;
   localparam logic [NUM_CH-1:0] MASK_RESET = {NUM_CH{1'b1}};

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_nch
      $error("NUM_CH must lie in 1..4 to fit the live-page map");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("ADDR_W must leave at least one base bit");
   end

   logic                          hit, odd;
   logic [5:0]                    ofs, wofs;
   logic                          rd_en, wr_en;
   logic [1:0]                    page_q;
   logic [15:0]                   freq_q;
   logic [NUM_CH-1:0]             mask_q;
   logic [3:0]                    tctrl_q;
   logic [NUM_CH-1:0][WORD_W-1:0] sig_q, exc_q, pos_h, vel_h;
   logic [NUM_CH-1:0]             rel_vec, lat_vec;
   logic                          latch_all;
   logic [15:0]                   cmd_q;
   logic                          cmd_wr, restore_fin;
   logic [15:0]                   word_val;
   logic                          word_map;
   logic [15:0]                   rdata_q;
   logic [7:0]                    hicap_q;

   function automatic logic [15:0] lane_put(input logic [15:0] old,
                                            input logic [15:0] wd,
                                            input logic        hi);
      return hi ? {wd[7:0], old[7:0]} : wd;
   endfunction

   pgh_window #(.ADDR_W(ADDR_W)) u_win (
      .addr(bus_addr), .base_sw(base_sw),
      .hit(hit), .ofs(ofs), .wofs(wofs), .odd(odd)
   );

   assign rd_en = bus_rd && hit;
   assign wr_en = bus_wr && hit;

   // page select, shared by all pages
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         page_q <= PG_LIVE;
      else if (wr_en && ofs == OFS_PAGE && bus_wdata[1:0] != PG_BAD)
         page_q <= bus_wdata[1:0];
   end

   assign latch_all = wr_en && page_q == PG_DRIVE && ofs == OFS_SNAP;
   assign cmd_wr    = wr_en && page_q == PG_LIVE && ofs == OFS_CMD;

   pgh_cmd u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
      .store_done(store_done), .cmd_q(cmd_q), .store_req(store_req),
      .store_restore(store_restore), .restore_fin(restore_fin)
   );

   // shared setup registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q  <= FREQ_RESET;
         mask_q  <= MASK_RESET;
         tctrl_q <= {post_en, 3'b000};
      end else begin
         if (restore_fin) begin
            freq_q <= FREQ_RESET;
            mask_q <= MASK_RESET;
         end else if (wr_en && page_q == PG_SETUP) begin
            if (wofs == OFS_FREQ) freq_q <= lane_put(freq_q, bus_wdata, odd);
            if (ofs == OFS_MASK)  mask_q <= bus_wdata[NUM_CH-1:0];
         end
         if (wr_en && page_q == PG_LIVE && ofs == OFS_TCTRL)
            tctrl_q <= bus_wdata[3:0] & TCTRL_WMASK;
         if (init_done)
            tctrl_q[TC_INIT_BIT] <= 1'b0;
      end
   end

   // per-channel holding and amplitude registers
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [5:0] POS_OFS = 6'(OFS_POS + 2 * c);
      localparam logic [5:0] SIG_OFS = 6'(OFS_SIG + 2 * c);
      localparam logic [5:0] EXC_OFS = 6'(OFS_EXC + 2 * c);

      assign rel_vec[c] = rd_en && page_q == PG_LIVE && ofs == POS_OFS;

      pgh_hold #(.W(WORD_W)) u_hold (
         .clk(clk), .rst_n(rst_n),
         .pos_in(pos_in[c*WORD_W +: WORD_W]),
         .vel_in(vel_in[c*WORD_W +: WORD_W]),
         .latch_all(latch_all), .rel_i(rel_vec[c]),
         .pos_q(pos_h[c]), .vel_q(vel_h[c]), .lat_q(lat_vec[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sig_q[c] <= SIG_RESET;
            exc_q[c] <= '0;
         end else if (restore_fin) begin
            sig_q[c] <= SIG_RESET;
            exc_q[c] <= '0;
         end else if (wr_en) begin
            if (page_q == PG_SETUP && wofs == SIG_OFS)
               sig_q[c] <= lane_put(sig_q[c], bus_wdata, odd);
            if (page_q == PG_DRIVE && wofs == EXC_OFS)
               exc_q[c] <= lane_put(exc_q[c], bus_wdata, odd);
         end
      end
   end

   // word-level read map
   always_comb begin
      word_val = '0;
      word_map = 1'b0;
      case (page_q)
         PG_LIVE: begin
            for (int i = 0; i < NUM_CH; i++) begin
               if (wofs == 6'(OFS_POS + 2 * i)) begin word_val = pos_h[i]; word_map = 1'b1; end
               if (wofs == 6'(OFS_VEL + 2 * i)) begin word_val = vel_h[i]; word_map = 1'b1; end
            end
            if (wofs == OFS_STAT) begin
               word_val = 16'({test_ok, exc_ok, sig_ok});
               word_map = 1'b1;
            end
            if (wofs == OFS_TCTRL) begin word_val = {12'b0, tctrl_q}; word_map = 1'b1; end
            if (wofs == OFS_CMD)   begin word_val = cmd_q;            word_map = 1'b1; end
         end
         PG_SETUP: begin
            if (wofs == OFS_FREQ) begin word_val = freq_q;          word_map = 1'b1; end
            if (wofs == OFS_MASK) begin word_val = 16'(mask_q);     word_map = 1'b1; end
            for (int i = 0; i < NUM_CH; i++)
               if (wofs == 6'(OFS_SIG + 2 * i)) begin word_val = sig_q[i]; word_map = 1'b1; end
         end
         PG_DRIVE: begin
            for (int i = 0; i < NUM_CH; i++)
               if (wofs == 6'(OFS_EXC + 2 * i)) begin word_val = exc_q[i]; word_map = 1'b1; end
            if (wofs == OFS_ID) begin word_val = ID_WORD; word_map = 1'b1; end
         end
         default: ;
      endcase
   end

   // registered read port with high-byte capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         hicap_q <= '0;
      end else if (bus_rd) begin
         if (!hit)                rdata_q <= '0;
         else if (ofs == OFS_PAGE) rdata_q <= {14'b0, page_q};
         else if (!word_map)      rdata_q <= '0;
         else if (odd)            rdata_q <= {8'b0, hicap_q};
         else begin
            rdata_q <= word_val;
            hicap_q <= word_val[15:8];
         end
      end
   end

   assign bus_rdata   = rdata_q;
   assign exc_freq    = freq_q;
   assign active_mask = mask_q;
   assign test_ctrl   = tctrl_q;
   assign sig_amp     = sig_q;
   assign exc_amp     = exc_q;

   logic unused_stat;
   assign unused_stat = ^STAT_W;
endmodule

// File: rtl/paged_host_regs_chk.sv
module paged_host_regs_chk #(
   parameter int NUM_CH = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_rd,
   input logic [15:0]            bus_rdata,
   input logic                   store_req,
   input logic                   store_restore,
   input logic                   store_done,
   input logic                   init_done,
   input logic [3:0]             test_ctrl,
   input logic [1:0]             page_q,
   input logic                   latch_all,
   input logic [NUM_CH-1:0]      rel_vec,
   input logic [NUM_CH-1:0]      lat_vec,
   input logic [NUM_CH-1:0][15:0] pos_h
);
   // R2
   page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_q != 2'd3);

   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R5
   snap_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_all |=> (&lat_vec));

   // R7
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req && store_done |=> !store_req);

   // R9
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req && !store_done |=> store_req && $stable(store_restore));

   // R11
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> !test_ctrl[3]);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R5
      frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lat_vec[i] |=> $stable(pos_h[i]));
      // R6
      release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rel_vec[i] && !latch_all |=> !lat_vec[i]);
   end
endmodule

bind paged_host_regs paged_host_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .store_req(store_req), .store_restore(store_restore),
   .store_done(store_done), .init_done(init_done), .test_ctrl(test_ctrl),
   .page_q(page_q), .latch_all(latch_all), .rel_vec(rel_vec),
   .lat_vec(lat_vec), .pos_h(pos_h)
);

// File: tb/paged_host_regs_tb.sv
`timescale 1ns/100ps
module paged_host_regs_tb;
   localparam int         NCH  = 4;
   localparam logic [3:0] BASE = 4'h5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0]  base_sw = BASE;
   logic [9:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [NCH*16-1:0] pos_in, vel_in, sig_amp, exc_amp;
   logic [NCH-1:0] sig_v = '0, exc_v = '0, test_v = '0, active_mask;
   logic post_en = 1'b1, init_done = 1'b0, store_done = 1'b0;
   logic store_req, store_restore;
   logic [15:0] exc_freq;
   logic [3:0]  test_ctrl;
   logic [15:0] pos_v [NCH];
   logic [15:0] vel_v [NCH];

   always #2.5 clk = ~clk;

   always_comb
      for (int c = 0; c < NCH; c++) begin
         pos_in[c*16 +: 16] = pos_v[c];
         vel_in[c*16 +: 16] = vel_v[c];
      end

   paged_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .base_sw(base_sw), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pos_in(pos_in), .vel_in(vel_in),
      .sig_ok(sig_v), .exc_ok(exc_v), .test_ok(test_v), .post_en(post_en),
      .init_done(init_done), .store_req(store_req),
      .store_restore(store_restore), .store_done(store_done),
      .exc_freq(exc_freq), .active_mask(active_mask), .test_ctrl(test_ctrl),
      .sig_amp(sig_amp), .exc_amp(exc_amp)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   // behavioural reference state
   logic [15:0] m_freq, m_mask, m_tctrl, m_page, m_cmd, m_hicap;
   logic [15:0] m_sig [NCH];
   logic [15:0] m_exc [NCH];
   logic [15:0] m_pos [NCH];
   logic [15:0] m_vel [NCH];
   bit m_lat [NCH];
   bit do_latch;
   bit do_rel [NCH];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic m_cfg_defaults();
      m_freq = 16'd400;
      m_mask = 16'hF;
      for (int c = 0; c < NCH; c++) begin m_sig[c] = 0; m_exc[c] = 0; end
   endtask

   task automatic m_reset(input bit pe);
      m_cfg_defaults();
      m_tctrl = pe ? 16'h8 : 16'h0;
      m_page = 0; m_cmd = 0; m_hicap = 0;
      for (int c = 0; c < NCH; c++) begin m_pos[c] = 0; m_vel[c] = 0; m_lat[c] = 0; end
   endtask

   function automatic logic [15:0] put(input logic [15:0] o, input logic [15:0] d, input bit hi);
      return hi ? {d[7:0], o[7:0]} : d;
   endfunction

   task automatic cycle();
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            m_pos[c] = 0; m_vel[c] = 0; m_lat[c] = 0;
         end else begin
            if (!m_lat[c]) begin m_pos[c] = pos_v[c]; m_vel[c] = vel_v[c]; end
            if (do_latch) m_lat[c] = 1;
            else if (do_rel[c]) m_lat[c] = 0;
         end
         do_rel[c] = 0;
      end
      do_latch = 0;
      if (rst_n && store_done && m_cmd != 0) begin
         if (m_cmd == 16'hAAAA) m_cfg_defaults();
         m_cmd = 0;
      end
      if (rst_n && init_done) m_tctrl = m_tctrl & 16'h7;
      @(posedge clk);
      #2;
      chk("R4 frequency output", exc_freq, m_freq);
      chk("R4 mask output", active_mask, m_mask);
      chk("R11 test control output", test_ctrl, m_tctrl);
      chk("R7 store_req", store_req, m_cmd != 0);
      chk("R8 store_restore", store_restore, m_cmd == 16'hAAAA);
      for (int c = 0; c < NCH; c++) begin
         chk("R4 signal amplitude output", sig_amp[c*16 +: 16], m_sig[c]);
         chk("R4 excitation amplitude output", exc_amp[c*16 +: 16], m_exc[c]);
      end
   endtask

   task automatic m_word(input logic [5:0] o, output logic [15:0] v, output bit map);
      int w;
      w = o & 6'h3E;
      v = 0; map = 0;
      if (m_page == 0) begin
         for (int c = 0; c < NCH; c++) begin
            if (w == 2 * c)     begin v = m_pos[c]; map = 1; end
            if (w == 8 + 2 * c) begin v = m_vel[c]; map = 1; end
         end
         if (w == 16'h10) begin v = {4'b0, test_v, exc_v, sig_v}; map = 1; end
         if (w == 16'h14) begin v = m_tctrl; map = 1; end
         if (w == 16'h1A) begin v = m_cmd; map = 1; end
      end else if (m_page == 1) begin
         if (w == 0) begin v = m_freq; map = 1; end
         if (w == 2) begin v = m_mask; map = 1; end
         for (int c = 0; c < NCH; c++)
            if (w == 4 + 2 * c) begin v = m_sig[c]; map = 1; end
      end else begin
         for (int c = 0; c < NCH; c++)
            if (w == 4 + 2 * c) begin v = m_exc[c]; map = 1; end
         if (w == 16'h18) begin v = 16'h4C44; map = 1; end
      end
   endtask

   task automatic wr(input logic [5:0] o, input logic [15:0] d, input logic [3:0] b = BASE);
      if (b == BASE) begin
         if (o == 6'h1F) begin
            if (d[1:0] != 2'd3) m_page = d[1:0];
         end else if (m_page == 0) begin
            if (o == 6'h14) m_tctrl = d & 16'hD;
            else if (o == 6'h1A && m_cmd == 0 && (d == 16'h5555 || d == 16'hAAAA)) m_cmd = d;
         end else if (m_page == 1) begin
            if ((o & 6'h3E) == 0) m_freq = put(m_freq, d, o[0]);
            else if (o == 2) m_mask = d & 16'hF;
            for (int c = 0; c < NCH; c++)
               if ((o & 6'h3E) == 4 + 2 * c) m_sig[c] = put(m_sig[c], d, o[0]);
         end else begin
            if (o == 0) do_latch = 1;
            for (int c = 0; c < NCH; c++)
               if ((o & 6'h3E) == 4 + 2 * c) m_exc[c] = put(m_exc[c], d, o[0]);
         end
      end
      bus_addr = {b, o}; bus_wdata = d; bus_wr = 1;
      cycle();
      bus_wr = 0;
   endtask

   task automatic rd(input logic [5:0] o, input string tag, input logic [3:0] b = BASE);
      logic [15:0] exp, v;
      bit map;
      if (b != BASE) exp = 0;
      else if (o == 6'h1F) exp = m_page;
      else begin
         m_word(o, v, map);
         if (!map) exp = 0;
         else if (o[0]) exp = {8'b0, m_hicap[7:0]};
         else begin exp = v; m_hicap = {8'b0, v[15:8]}; end
         if (m_page == 0 && !o[0] && o < 2 * NCH) do_rel[o >> 1] = 1;
      end
      bus_addr = {b, o}; bus_rd = 1;
      cycle();
      chk(tag, bus_rdata, exp);
      bus_rd = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin pos_v[c] = 0; vel_v[c] = 0; do_rel[c] = 0; end
      do_latch = 0;
      m_reset(1);
      repeat (3) cycle();
      rst_n = 1;
      cycle();
      chk("R10 frequency after reset", exc_freq, 16'd400);
      chk("R10 test control after reset", test_ctrl, 4'h8);
      chk("R10 no command after reset", store_req, 1'b0);
      rd(6'h1F, "R10 page after reset");

      pos_v[0] = 16'h1234; pos_v[1] = 16'hABCD; pos_v[2] = 16'h7FFF; pos_v[3] = 16'h8000;
      vel_v[0] = 16'h0630; vel_v[1] = 16'hFFF0; vel_v[2] = 16'h0001; vel_v[3] = 16'h4321;
      sig_v = 4'b1011; exc_v = 4'b0110; test_v = 4'b1001;
      cycle();
      rd(6'h00, "R1 read outside window", 4'h3);
      wr(6'h1F, 16'h0002, 4'h3);
      rd(6'h1F, "R1 foreign write leaves page");

      rd(6'h00, "R3 position word ch0");
      rd(6'h01, "R3 high byte after its word");
      rd(6'h02, "R3 position word ch1");
      rd(6'h07, "R3 odd read returns captured byte");
      rd(6'h0A, "R5 velocity ch1");
      rd(6'h10, "R13 health word");

      wr(6'h1F, 16'h0002);
      wr(6'h00, 16'h0000);
      for (int c = 0; c < NCH; c++) begin pos_v[c] = pos_v[c] ^ 16'h0F0F; vel_v[c] = vel_v[c] + 16'd5; end
      repeat (2) cycle();
      wr(6'h1F, 16'h0000);
      rd(6'h02, "R5 ch1 frozen at snapshot");
      rd(6'h0C, "R6 ch2 velocity still frozen");
      rd(6'h0A, "R6 ch1 velocity tracks after release");
      rd(6'h02, "R6 ch1 position tracks after release");
      rd(6'h06, "R6 ch3 position still frozen");
      rd(6'h06, "R6 ch3 tracks after its own read");

      wr(6'h1F, 16'h0003);
      rd(6'h1F, "R2 page value 3 ignored");
      wr(6'h1F, 16'h0001);
      rd(6'h1F, "R2 setup page selected");
      wr(6'h00, 16'h0320);
      wr(6'h01, 16'h0012);
      rd(6'h00, "R4 frequency after high-lane write");
      wr(6'h02, 16'hFF05);
      rd(6'h02, "R4 mask keeps low byte");
      wr(6'h08, 16'h0A97);
      rd(6'h08, "R4 signal amplitude ch2");
      rd(6'h1C, "R12 unmapped read is zero");
      wr(6'h1C, 16'hFFFF);
      rd(6'h1D, "R12 unmapped odd read is zero");

      wr(6'h1F, 16'h0002);
      wr(6'h0A, 16'h0A28);
      rd(6'h0A, "R4 excitation amplitude ch3");
      rd(6'h18, "R12 identification word");
      rd(6'h00, "R12 snapshot register reads zero");

      wr(6'h1F, 16'h0000);
      wr(6'h1A, 16'h1234);
      rd(6'h1A, "R9 invalid command ignored");
      wr(6'h1A, 16'h5555);
      rd(6'h1A, "R7 save command pending");
      wr(6'h1A, 16'hAAAA);
      rd(6'h1A, "R9 command ignored while busy");
      store_done = 1; cycle(); store_done = 0;
      rd(6'h1A, "R7 command cleared on completion");
      wr(6'h1A, 16'hAAAA);
      chk("R8 restore requested", store_restore, 1'b1);
      store_done = 1; cycle(); store_done = 0;
      chk("R8 frequency restored", exc_freq, 16'd400);
      rd(6'h1A, "R8 command cleared after restore");

      wr(6'h14, 16'hFFFF);
      rd(6'h14, "R11 only writable test bits set");
      init_done = 1; cycle(); init_done = 0;
      rd(6'h14, "R11 initiated test bit cleared");

      post_en = 0; rst_n = 0;
      m_reset(0);
      repeat (2) cycle();
      rst_n = 1;
      cycle();
      chk("R10 test control without power-on test", test_ctrl, 4'h0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule